// File: doc/BRIEF.md
# Non-Retriggerable Clocked One-Shot Pulse Generator

This block is a synchronous monostable. Three asynchronous control inputs pass through synchronisers. They are then watched for the transitions that start a pulse. When a start condition is met, the output Q goes high for a number of clock cycles given by a 16-bit width input. QN carries the opposite level. Trigger transitions that arrive while a pulse is in progress do not change that pulse.

The inputs are:
- a falling-edge trigger, which is active low;
- a rising-edge trigger, which is active high;
- an active-low clear.

Holding clear low forces the output idle and cuts short any running pulse. Clear can also start a pulse when it is released, but only after a specific sequence. The rising-edge trigger must have gone high while clear was still low, and the falling-edge trigger must be low when clear rises. The block tracks that condition with an internal armed flag.

Every input passes through a two-flop synchroniser, and the output is registered. As a result, Q reacts on the third rising clock edge after an input changes.

Top module: `oneshot_gen`

## Requirements
- R1: While `rst_n` is low, `q_o` is 0 and `qn_o` is 1. Asserting `rst_n` low ends a running pulse at once, without waiting for a clock edge.
- R2: While `clr_n_i` is low, `q_o` is 0 from the third rising clock edge after clear falls. No trigger transition seen during this time starts a pulse.
- R3: If `fall_trig_i` goes from 1 to 0 while `rise_trig_i` is 1 and `clr_n_i` is 1, one pulse starts. `q_o` rises on the third rising clock edge after the input change.
- R4: If `rise_trig_i` goes from 0 to 1 while `fall_trig_i` is 0 and `clr_n_i` is 1, one pulse starts with the same latency as in R3.
- R5: A 0-to-1 change of `clr_n_i`, with `fall_trig_i` at 0 and `rise_trig_i` at 1, starts a pulse only under two conditions:
  - `rise_trig_i` went from 0 to 1 while clear was low;
  - `rise_trig_i` has stayed at 1 since then, and no earlier clear release has used that rise.

  A clear release that finds `fall_trig_i` high does not use the rise.
- R6: The generator cannot be retriggered. Trigger transitions during a pulse neither restart it nor lengthen it.
- R7: Taking `clr_n_i` low during a pulse ends that pulse. `q_o` falls on the third rising clock edge after the clear input falls.
- R8: `qn_o` always equals the inverse of `q_o`.
- R9: If `fall_trig_i` is held at 1, or `rise_trig_i` is held at 0, no transition on the other trigger input starts a pulse.
- R10: A pulse keeps `q_o` high for exactly W clock cycles. W is the value of `width_i` in the cycle the trigger is accepted, and a value of 0 gives 1 cycle. A change to `width_i` after that cycle does not affect the running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| fall_trig_i | input | 1 | Trigger input that acts on its falling edge |
| rise_trig_i | input | 1 | Trigger input that acts on its rising edge |
| clr_n_i | input | 1 | Clear, active low; its release may also start a pulse |
| width_i | input | CNT_W (16) | Pulse length in clock cycles; 0 means 1 |
| q_o | output | 1 | Pulse output, active high |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
The assertions check several properties on every cycle:
- no start is decoded while clear is low, or while either trigger sits at its blocking level;
- a running count decreases by exactly one per cycle and stops when it reaches zero;
- clear kills the pulse by the next cycle;
- the armed flag drops whenever the rising trigger is low.

Some behaviour shows up only in the bench's scenarios. This covers the full end-to-end latency through the synchronisers and the exact pulse lengths for several widths. It also covers the clear-release sequences that fire against those that do not, and the fact that changing the width during a pulse has no effect.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronised view of the three control inputs.
    typedef struct packed {
        logic clr_n;    // clear, active low
        logic fall_in;  // trigger acting on its falling edge
        logic rise_in;  // trigger acting on its rising edge
    } trig_in_t;

    localparam int NUM_CTRL = $bits(trig_in_t);

    // Idle levels used for both synchroniser and history reset.
    localparam trig_in_t CTRL_IDLE = '{clr_n: 1'b1, fall_in: 1'b1, rise_in: 1'b0};

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
            else        chain_q <= chain_d;
        end

        assign sync_o[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig
    import oneshot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  trig_in_t cur_i,
    output logic     fire_o,
    output logic     clr_act_o
);

    typedef struct packed {
        trig_in_t prev;
        logic     armed;
    } trg_st_t;

    trg_st_t st_q, st_d;
    logic    fall_edge, rise_edge, clr_edge;
    logic    fire_fall, fire_rise, fire_rel;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cur_i;

        fall_edge = st_q.prev.fall_in & ~cur_i.fall_in;
        rise_edge = ~st_q.prev.rise_in & cur_i.rise_in;
        clr_edge  = ~st_q.prev.clr_n & cur_i.clr_n;

        fire_fall = fall_edge & cur_i.rise_in & cur_i.clr_n;
        fire_rise = rise_edge & ~cur_i.fall_in & cur_i.clr_n;
        fire_rel  = clr_edge & ~cur_i.fall_in & cur_i.rise_in & st_q.armed;

        if (!cur_i.rise_in)                 st_d.armed = 1'b0;
        else if (rise_edge && !cur_i.clr_n) st_d.armed = 1'b1;
        else if (fire_rel)                  st_d.armed = 1'b0;

        fire_o    = fire_fall | fire_rise | fire_rel;
        clr_act_o = ~cur_i.clr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: CTRL_IDLE, armed: 1'b0};
        else        st_q <= st_d;
    end

    // R2
    no_fire_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_i.clr_n |-> !fire_o);

    // R9
    fall_high_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_i.fall_in |-> !fire_o);

    // R9
    rise_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_i.rise_in |-> !fire_o);

    // R5
    disarm_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_i.rise_in |=> !st_q.armed);

    // R5
    release_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_edge && !st_q.armed && !fall_edge && !rise_edge) |-> !fire_o);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             clr_act_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] left;
    } tmr_st_t;

    tmr_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_act_i) begin
            st_d.run  = 1'b0;
            st_d.left = '0;
        end else if (st_q.run) begin
            if (st_q.left == '0) st_d.run  = 1'b0;
            else                 st_d.left = st_q.left - 1'b1;
        end else if (fire_i) begin
            st_d.run  = 1'b1;
            st_d.left = (width_i == '0) ? '0 : width_i - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.run;

    // R7
    clear_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act_i |=> !st_q.run);

    // R6
    steady_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.left != '0 && !clr_act_i)
        |=> (st_q.run && st_q.left == $past(st_q.left) - 1'b1));

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !st_q.run && !clr_act_i) |=> st_q.run);

    // R10
    last_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.left == '0) |=> !st_q.run);

endmodule

// File: rtl/oneshot_gen.sv
module oneshot_gen
    import oneshot_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_trig_i,
    input  logic             rise_trig_i,
    input  logic             clr_n_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             q_o,
    output logic             qn_o
);

    trig_in_t raw_ctrl, sync_ctrl;
    logic     fire, clr_act, pulse;

    assign raw_ctrl = '{clr_n: clr_n_i, fall_in: fall_trig_i, rise_in: rise_trig_i};

    oneshot_sync #(
        .W       (NUM_CTRL),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTRL_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_ctrl),
        .sync_o  (sync_ctrl)
    );

    oneshot_trig u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_i     (sync_ctrl),
        .fire_o    (fire),
        .clr_act_o (clr_act)
    );

    oneshot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .clr_act_i (clr_act),
        .width_i   (width_i),
        .pulse_o   (pulse)
    );

    assign q_o  = pulse;
    assign qn_o = ~pulse;

endmodule

// File: tb/oneshot_gen_tb.sv
module oneshot_gen_tb;

    localparam int CNT_W = 16;
    localparam int LAT   = 3;   // edges from input change to q_o
    localparam int NVEC  = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fall_trig = 1'b1;
    logic             rise_trig = 1'b0;
    logic             clr_n = 1'b1;
    logic [CNT_W-1:0] width = 16'd3;
    logic             q, qn;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    oneshot_gen #(.CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_trig_i (fall_trig),
        .rise_trig_i (rise_trig),
        .clr_n_i     (clr_n),
        .width_i     (width),
        .q_o         (q),
        .qn_o        (qn)
    );

    // {clr_n, fall_trig, rise_trig, q expected LAT edges later}; width 3
    localparam logic [3:0] VEC [0:NVEC-1] = '{
        4'b1100, 4'b1000, 4'b1011, 4'b1011, 4'b1011, // 0-4  R9 then R4 pulse
        4'b1010, 4'b1000, 4'b1100, 4'b1110, 4'b1011, // 5-9  R9 block, R3 fire
        4'b1111, 4'b1011, 4'b1010, 4'b1110, 4'b1011, // 10-14 R6 ignore, R3
        4'b0010, 4'b0000, 4'b0010, 4'b1011, 4'b1011, // 15-19 R7 cut, R5 fire
        4'b1011, 4'b1010, 4'b0010, 4'b1010, 4'b1010, // 20-24 R5 no arm
        4'b0000, 4'b0010, 4'b0000, 4'b0100, 4'b0110, // 25-29 R2 hold
        4'b1110, 4'b1110, 4'b0110, 4'b0010, 4'b0010, // 30-34 R5 A high, R2
        4'b1011, 4'b1011, 4'b1011, 4'b1010, 4'b1010  // 35-39 R5 armed fire
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic measure(input logic [CNT_W-1:0] w, input int change_after,
                           input logic [CNT_W-1:0] w2, output int len);
        width     = w;
        clr_n     = 1'b1;
        rise_trig = 1'b1;
        fall_trig = 1'b1;
        repeat (4) @(negedge clk);
        fall_trig = 1'b0;
        len = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (q) begin
                len++;
                if (len == change_after) width = w2;
            end
        end
        fall_trig = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : stim
        int len;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 q in reset", q, 1'b0);
        check("R1 qn in reset", qn, 1'b1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk: drive row i, compare row i-LAT
        for (int i = 0; i < NVEC + LAT; i++) begin
            if (i >= LAT) begin
                check($sformatf("R2-R9 vec %0d", i - LAT), q, VEC[i-LAT][0]);
                check("R8 qn inverse", qn, ~q);
            end
            if (i < NVEC) begin
                clr_n     = VEC[i][3];
                fall_trig = VEC[i][2];
                rise_trig = VEC[i][1];
            end
            @(negedge clk);
        end

        // R10 zero width gives one cycle
        measure(16'd0, 0, 16'd0, len);
        check("R10 width 0 length", len == 1, 1'b1);
        if (len != 1) $display("  R10 len %0d", len);
        // R3 length tracks width
        measure(16'd1, 0, 16'd0, len);
        check("R3 width 1 length", len == 1, 1'b1);
        measure(16'd7, 0, 16'd0, len);
        check("R3 width 7 length", len == 7, 1'b1);
        if (len != 7) $display("  R3 len %0d", len);
        // R10 width change mid-pulse has no effect
        measure(16'd4, 2, 16'd12, len);
        check("R10 width sampled at start", len == 4, 1'b1);
        if (len != 4) $display("  R10 len %0d", len);

        // R1 async reset mid-pulse
        width = 16'd20;
        repeat (3) @(negedge clk);
        fall_trig = 1'b0;
        repeat (6) @(negedge clk);
        check("R1 pulse running before reset", q, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R1 async reset q", q, 1'b0);
        check("R1 async reset qn", qn, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        fall_trig = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle after reset", q, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule